// File: doc/BRIEF.md
# Quadrature X4 Position Counter with Ceiling Wrap

This block turns the two phase signals of an incremental encoder into a position count. Both phases are assumed to be already clean and synchronous to the block clock. The block uses four-times decoding: every rising and every falling edge of either phase moves the count by one. The sign of the step follows which phase leads. The count runs between zero and a programmable ceiling and wraps at both ends. Each wrap raises a one-cycle event pulse, one for each direction. A third event pulse reports a change of direction.

An index pulse can also clear the count. It does so only on its rising edge, and only when the two phase pins sit at the level pair chosen by a two-bit gate code. A mode input turns this index clearing off, which leaves the ceiling wrap as the only way the count resets. Two phases that toggle in the same clock cycle form an illegal transition. Such a transition sets a sticky phase-error flag and does not move the count.

The ceiling, the phase swap, the index mode and the gate code are captured only while the enable input is low. A running counter therefore cannot have its setup changed under it. While disabled, the counter holds its count and direction.

Top module: `qx4_counter`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `dir_down_o` is 0, `phase_err_o` is 0 and all three event pulses are low.
- R2: With swap off and the block enabled, a change of exactly one phase moves the count by one. It steps up along the (A,B) sequence 00, 10, 11, 01 and down along the reverse sequence. The new value is visible on the first clock edge that samples the changed pin.
- R3: With swap set, A and B exchange roles, so the same pin sequence counts in the opposite direction.
- R4: An up step taken from a count at or above the ceiling loads 0 and pulses `wrap_up_o` for one cycle. A down step taken from 0 loads the ceiling and pulses `wrap_down_o` for one cycle. The two pulses are never high together.
- R5: `dir_down_o` (1 = down) takes the direction of the most recent valid step. `dir_change_o` pulses for one cycle when a step reverses the stored direction.
- R6: When both phases change in the same cycle while enabled, `phase_err_o` goes high and stays high, and the count is unchanged. The flag clears on the first edge with enable low.
- R7: With the index mode input low, an index rising edge clears the count to 0. It does so only if the raw pin levels equal the gate code, where bit 1 is the level needed on A and bit 0 the level needed on B. The clear takes priority over a step in the same cycle and pulses `wrap_up_o` if the stored direction is up, or `wrap_down_o` if it is down.
- R8: With the index mode input high, the index pin has no effect on the count or on the event pulses.
- R9: With enable low, the count and direction hold and no event pulse is raised.
- R10: The ceiling, swap, index mode and gate code are captured on edges where enable is low. Changes to them while enable is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Counting enable; low also opens the setup capture |
| swap_i | input | 1 | Exchange the roles of phase A and phase B |
| idx_off_i | input | 1 | High: index never clears the count |
| idx_gate_i | input | 2 | Required pin levels for index clear, {A,B} |
| ceiling_i | input | CNT_W | Highest count value before wrap |
| phase_a_i | input | 1 | Phase A, clean and synchronous |
| phase_b_i | input | 1 | Phase B, clean and synchronous |
| index_i | input | 1 | Index pulse, clean and synchronous |
| count_o | output | CNT_W | Position count |
| dir_down_o | output | 1 | Direction of the last valid step, 1 = down |
| phase_err_o | output | 1 | Sticky illegal-transition flag |
| dir_change_o | output | 1 | One-cycle pulse on direction reversal |
| wrap_up_o | output | 1 | One-cycle pulse on upward wrap or index clear while up |
| wrap_down_o | output | 1 | One-cycle pulse on downward wrap or index clear while down |

## Verification
A wrong stored previous-phase value shows up on `count_o` one cycle after the next pin change, as a missing step, a step with the wrong sign or a false phase error. A wrong stored direction shows up at once as a spurious or missing `dir_change_o`, or as an index clear signalled on the wrong wrap pulse. A stale or leaking setup register shows up only at the next wrap, so the sweep keeps the ceiling small and moves the ceiling input while enabled. The sweep runs every combination of swap, index mode and gate code against a model in the bench, and each mismatch is visible within one clock.

// File: rtl/qx4_pkg.sv
package qx4_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } qx4_step_e;

    typedef struct packed {
        logic       swap;
        logic       idx_off;
        logic [1:0] gate;
    } qx4_cfg_t;

    localparam qx4_cfg_t QX4_CFG_RESET = '{swap: 1'b0, idx_off: 1'b0, gate: 2'b00};

    // Classify a transition of the (already swapped) phase pair.
    function automatic qx4_step_e qx4_classify(input logic a_now, input logic b_now,
                                               input logic a_old, input logic b_old);
        logic chg_a;
        logic chg_b;
        chg_a = a_now ^ a_old;
        chg_b = b_now ^ b_old;
        if (chg_a && chg_b)
            return STEP_BAD;
        else if (chg_a || chg_b)
            return (a_now ^ b_old) ? STEP_UP : STEP_DOWN;
        else
            return STEP_NONE;
    endfunction

    // Gate code bit 1 is the level required on A, bit 0 the level on B.
    function automatic logic qx4_gate_ok(input logic [1:0] code, input logic a, input logic b);
        return (code[1] == a) && (code[0] == b);
    endfunction

endpackage

// File: rtl/qx4_phase_decode.sv
module qx4_phase_decode
    import qx4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      swap_i,
    input  logic      a_i,
    input  logic      b_i,
    output qx4_step_e step_o
);
    logic a_old_q;
    logic b_old_q;
    logic a_now_s;
    logic b_now_s;
    logic a_old_s;
    logic b_old_s;

    // Previous raw levels follow the pins at all times, including reset,
    // so that enabling never sees a phantom transition.
    always_ff @(posedge clk) begin
        a_old_q <= a_i;
        b_old_q <= b_i;
    end

    always_comb begin
        a_now_s = swap_i ? b_i : a_i;
        b_now_s = swap_i ? a_i : b_i;
        a_old_s = swap_i ? b_old_q : a_old_q;
        b_old_s = swap_i ? a_old_q : b_old_q;
        step_o  = qx4_classify(a_now_s, b_now_s, a_old_s, b_old_s);
    end

    AST_BAD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (step_o == STEP_BAD) |-> ((a_i != $past(a_i)) && (b_i != $past(b_i)))); // R6

endmodule

// File: rtl/qx4_index_gate.sv
module qx4_index_gate
    import qx4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_i,
    input  logic       a_i,
    input  logic       b_i,
    input  logic       off_i,
    input  logic [1:0] gate_i,
    output logic       hit_o
);
    logic idx_old_q;

    always_ff @(posedge clk) begin
        idx_old_q <= idx_i;
    end

    always_comb begin
        hit_o = idx_i && !idx_old_q && !off_i && qx4_gate_ok(gate_i, a_i, b_i);
    end

    AST_HIT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (idx_i && !$past(idx_i))); // R7

endmodule

// File: rtl/qx4_position.sv
module qx4_position
    import qx4_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  qx4_step_e        step_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] ceil_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             perr_o,
    output logic             dir_chg_o,
    output logic             wrap_up_o,
    output logic             wrap_dn_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_step;
    logic             dir_q;
    logic             dir_nxt;
    logic             perr_q;
    logic             step_wrap_up;
    logic             step_wrap_dn;
    logic             chg_q;
    logic             up_q;
    logic             dn_q;

    always_comb begin
        cnt_step     = cnt_q;
        step_wrap_up = 1'b0;
        step_wrap_dn = 1'b0;
        dir_nxt      = dir_q;
        unique case (step_i)
            STEP_UP: begin
                dir_nxt = 1'b0;
                if (cnt_q >= ceil_i) begin
                    cnt_step     = ZERO;
                    step_wrap_up = 1'b1;
                end else begin
                    cnt_step = cnt_q + ONE;
                end
            end
            STEP_DOWN: begin
                dir_nxt = 1'b1;
                if (cnt_q == ZERO) begin
                    cnt_step     = ceil_i;
                    step_wrap_dn = 1'b1;
                end else begin
                    cnt_step = cnt_q - ONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            dir_q  <= 1'b0;
            perr_q <= 1'b0;
            chg_q  <= 1'b0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
        end else if (!en_i) begin
            perr_q <= 1'b0;
            chg_q  <= 1'b0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
        end else begin
            dir_q <= dir_nxt;
            chg_q <= (dir_nxt != dir_q);
            if (step_i == STEP_BAD)
                perr_q <= 1'b1;
            if (hit_i) begin
                cnt_q <= ZERO;
                up_q  <= !dir_q;
                dn_q  <= dir_q;
            end else begin
                cnt_q <= cnt_step;
                up_q  <= step_wrap_up;
                dn_q  <= step_wrap_dn;
            end
        end
    end

    assign count_o    = cnt_q;
    assign dir_down_o = dir_q;
    assign perr_o     = perr_q;
    assign dir_chg_o  = chg_q;
    assign wrap_up_o  = up_q;
    assign wrap_dn_o  = dn_q;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(cnt_q) && $stable(dir_q) && !up_q && !dn_q && !chg_q)); // R9
    AST_WRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_q, dn_q})); // R4
    AST_DIR_PULSE: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> (dir_q != $past(dir_q))); // R5
    AST_BAD_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (en_i && step_i == STEP_BAD && !hit_i) |=> $stable(cnt_q)); // R6
    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (en_i && hit_i) |=> (cnt_q == ZERO)); // R7

endmodule

// File: rtl/qx4_counter.sv
module qx4_counter
    import qx4_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             swap_i,
    input  logic             idx_off_i,
    input  logic [1:0]       idx_gate_i,
    input  logic [CNT_W-1:0] ceiling_i,
    input  logic             phase_a_i,
    input  logic             phase_b_i,
    input  logic             index_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             phase_err_o,
    output logic             dir_change_o,
    output logic             wrap_up_o,
    output logic             wrap_down_o
);
    qx4_cfg_t         cfg_q;
    logic [CNT_W-1:0] ceil_q;
    qx4_step_e        step_s;
    logic             hit_s;

    // Setup is captured only while counting is stopped.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= QX4_CFG_RESET;
            ceil_q <= '1;
        end else if (!enable_i) begin
            cfg_q  <= '{swap: swap_i, idx_off: idx_off_i, gate: idx_gate_i};
            ceil_q <= ceiling_i;
        end
    end

    qx4_phase_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .swap_i (cfg_q.swap),
        .a_i    (phase_a_i),
        .b_i    (phase_b_i),
        .step_o (step_s)
    );

    qx4_index_gate u_index (
        .clk    (clk),
        .rst    (rst),
        .idx_i  (index_i),
        .a_i    (phase_a_i),
        .b_i    (phase_b_i),
        .off_i  (cfg_q.idx_off),
        .gate_i (cfg_q.gate),
        .hit_o  (hit_s)
    );

    qx4_position #(.CNT_W(CNT_W)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .en_i       (enable_i),
        .step_i     (step_s),
        .hit_i      (hit_s),
        .ceil_i     (ceil_q),
        .count_o    (count_o),
        .dir_down_o (dir_down_o),
        .perr_o     (phase_err_o),
        .dir_chg_o  (dir_change_o),
        .wrap_up_o  (wrap_up_o),
        .wrap_dn_o  (wrap_down_o)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        enable_i |=> ($stable(cfg_q) && $stable(ceil_q))); // R10
    AST_IDX_MUTED: assert property (@(posedge clk) disable iff (rst)
        cfg_q.idx_off |-> !hit_s); // R8

endmodule

// File: tb/qx4_counter_tb_top.sv
module qx4_counter_tb_top;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         en = 1'b0, swp = 1'b0, ioff = 1'b0;
    logic [1:0]   gsel = 2'b00;
    logic [W-1:0] ceil_in = '0;
    logic         pa = 1'b0, pb = 1'b0, px = 1'b0;

    logic [W-1:0] count;
    logic         dir_down, perr, dchg, wup, wdn;

    qx4_counter #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .enable_i(en), .swap_i(swp), .idx_off_i(ioff),
        .idx_gate_i(gsel), .ceiling_i(ceil_in), .phase_a_i(pa), .phase_b_i(pb),
        .index_i(px), .count_o(count), .dir_down_o(dir_down), .phase_err_o(perr),
        .dir_change_o(dchg), .wrap_up_o(wup), .wrap_down_o(wdn)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [W-1:0] m_cnt = '0, m_ceil = '1;
    logic m_dir = 0, m_perr = 0, m_swp = 0, m_ioff = 0;
    logic [1:0] m_g = 0;
    logic la = 0, lb = 0, lx = 0;
    logic e_chg = 0, e_up = 0, e_dn = 0;
    string cnt_tag = "R1";

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(cnt_tag, "count", count, m_cnt);
        chk("R5", "dir_down", W'(dir_down), W'(m_dir));
        chk("R6", "phase_err", W'(perr), W'(m_perr));
        chk("R5", "dir_change", W'(dchg), W'(e_chg));
        chk("R4", "wrap_up", W'(wup), W'(e_up));
        chk("R4", "wrap_down", W'(wdn), W'(e_dn));
    endtask

    // Apply one vector at the falling edge, predict, then check after the rising edge.
    task automatic apply(input logic a, input logic b, input logic x, input logic e,
                         input logic [W-1:0] cin);
        logic ca, cb, oa, ob, up, hit, od, wu, wd;
        logic [W-1:0] nc;
        pa = a; pb = b; px = x; en = e; ceil_in = cin;
        e_chg = 0; e_up = 0; e_dn = 0; wu = 0; wd = 0;
        ca = m_swp ? b : a;   cb = m_swp ? a : b;
        oa = m_swp ? lb : la; ob = m_swp ? la : lb;
        cnt_tag = m_swp ? "R3" : "R2";
        if (e) begin
            // R7 / R8: index clear needs rising edge, mode low and matching levels
            hit = x && !lx && !m_ioff && (a == m_g[1]) && (b == m_g[0]);
            if (x && !lx && m_ioff) cnt_tag = "R8";
            if (cin != m_ceil) cnt_tag = "R10";
            od = m_dir;
            nc = m_cnt;
            if ((ca != oa) && (cb != ob)) begin
                m_perr = 1;
            end else if ((ca != oa) || (cb != ob)) begin
                up = ca ^ ob;
                if (up) begin
                    if (m_cnt >= m_ceil) begin nc = '0; wu = 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nc = m_ceil; wd = 1; end
                    else nc = m_cnt - 1;
                end
                e_chg = (m_dir != !up);
                m_dir = !up;
            end
            if (hit) begin
                nc = '0; e_up = !od; e_dn = od; cnt_tag = "R7";
            end else begin
                e_up = wu; e_dn = wd;
                if (wu || wd) cnt_tag = "R4";
            end
            m_cnt = nc;
        end else begin
            cnt_tag = "R9";
            m_perr = 0;
            m_swp = swp; m_ioff = ioff; m_g = gsel; m_ceil = cin;  // R10 capture
        end
        la = a; lb = b; lx = x;
        @(posedge clk);
        #2;
        compare_all();
        @(negedge clk);
    endtask

    function automatic logic [1:0] pos2ab(input logic [1:0] p);
        case (p)
            2'd0: return 2'b00;
            2'd1: return 2'b10;
            2'd2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    initial begin
        logic [15:0] lfsr;
        logic [1:0]  p;
        logic [1:0]  ab;
        logic [W-1:0] cin;
        lfsr = 16'hACE1;
        p = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        cnt_tag = "R1";
        compare_all();   // R1 reset state
        @(negedge clk);

        // R2: directed up run then down run with swap off, ceiling 3
        swp = 0; ioff = 1; gsel = 0;
        apply(0, 0, 0, 0, W'(3));
        for (int i = 0; i < 6; i++) begin
            p = p + 1; ab = pos2ab(p); apply(ab[1], ab[0], 0, 1, W'(3));
        end
        for (int i = 0; i < 6; i++) begin
            p = p - 1; ab = pos2ab(p); apply(ab[1], ab[0], 0, 1, W'(3));
        end

        // Sweep every swap / index-mode / gate combination (R3, R7, R8, R10)
        for (int c = 0; c < 16; c++) begin
            swp  = c[0];
            ioff = c[1];
            gsel = c[3:2];
            cin  = W'(2 + (c % 5));
            ab = pos2ab(p);
            apply(ab[1], ab[0], 0, 0, cin);
            for (int k = 0; k < 64; k++) begin
                logic [W-1:0] cv;
                logic ev;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (lfsr[1:0])
                    2'd0: p = p + 1;
                    2'd1: p = p - 1;
                    2'd2: p = p + 2;    // R6: both phases toggle
                    default: ;
                endcase
                ab = pos2ab(p);
                ev = (lfsr[6:3] != 4'd0);
                cv = (lfsr[10:7] == 4'd0) ? W'(lfsr[15:13]) : cin;
                if (!ev) cin = cv;
                apply(ab[1], ab[0], lfsr[2], ev, cv);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule